// File: doc/BRIEF.md
# Multiplexed-Address Dynamic Memory Controller

This controller connects a simple host request port to a byte-wide dynamic memory module that has only half as many address pins as address bits. The host presents a full byte address, a direction flag and write data under a valid/ready handshake. The controller sends the upper half of the address as a row over the shared pins under an active-low row strobe. It then sends the lower half as a column under an active-low column strobe, moves one byte in parallel, and answers with a one-cycle done pulse that carries the read byte.

A row stays open after an access. A later request to the same row goes straight to the column phase, and a request to a different row first closes the open row and waits out a precharge time. A timer derived from the clock rate and the retention period raises refresh requests. Each request is served at the next idle point, ahead of any waiting host request. The controller closes any open row and then strobes the next row of an internal refresh counter with the row strobe alone.

Top module: `dram_mux_ctrl`

## Requirements
- R1: The row is address bits [19:10], presented on `mem_addr` when `mem_ras_n` falls. The column is bits [9:0], presented when `mem_cas_n` falls. A read returns the byte stored at the full address, and unwritten locations are left to the memory.
- R2: `mem_addr` holds the same value in the cycle before each falling edge of either strobe as on that edge. `mem_cas_n` is low only while `mem_ras_n` is low.
- R3: `mem_we_n` is active low, and 0 means write. It is low only during the column-strobe cycle of a write, with `mem_dq_oe` high and `mem_dq_out` equal to the request's write data. During a read column strobe, `mem_we_n` is 1 and `mem_dq_oe` is 0.
- R4: Out of reset `req_ready` is 1 and all strobes are high. A request is accepted on a clock edge with `req_valid` and `req_ready` both high. `req_ready` is 0 in the following cycle and stays 0 while an access or refresh is in progress or a refresh is pending.
- R5: Each accepted request produces exactly one `rsp_done` pulse, one cycle wide. For a read, `rsp_rdata` holds the byte in that cycle.
- R6: If the previous access left the same row open and no refresh came between, the access issues no row strobe. Otherwise it issues exactly one row-strobe falling edge.
- R7: `mem_ras_n` is high for at least PRE_CYC+1 consecutive cycles before each of its falling edges. This is the precharge time plus one address setup cycle.
- R8: A refresh is a row-strobe pulse with no column strobe. Its address is a refresh row counter that starts at 0 after reset, advances by one per refresh and wraps from 1023 to 0. A refresh closes any open row.
- R9: Refreshes are spaced no more than REF_INTERVAL+20 cycles apart, counting the first from reset. REF_INTERVAL defaults to CLK_KHZ*RETENTION_MS/1024.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Byte address (row = [19:10], column = [9:0]) |
| req_wdata | input | 8 | Write byte |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read byte, valid with rsp_done on reads |
| mem_addr | output | 10 | Multiplexed row/column/refresh address |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Output enable for mem_dq_out |
| mem_dq_in | input | 8 | Data returned by the memory |

## Verification
Back-to-back accesses inside one row show that the row phase is skipped. Sequential addresses that step across a row boundary show the close, precharge and re-open path. A scattered mix of reads and writes over four rows lets refreshes land between accesses, so row re-opening after a refresh is told apart from a true hit. The lowest and highest addresses confirm the row/column split at its extremes. A long idle stretch makes the refresh row counter wrap and checks the spacing of refreshes when no traffic competes with them.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PRE,
      ST_RSET,
      ST_RAS,
      ST_CSET,
      ST_CAS,
      ST_FSET,
      ST_FRAS
   } ctrl_st_e;

   typedef enum logic [1:0] {
      PT_IDLE,
      PT_ROW,
      PT_REF
   } pre_tgt_e;

   typedef enum logic [1:0] {
      SEL_ROW,
      SEL_COL,
      SEL_REF
   } addr_sel_e;

endpackage

// File: rtl/dram_ref_timer.sv
module dram_ref_timer #(
   parameter int unsigned INTERVAL = 1562,
   localparam int unsigned CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ack,
   output logic pend
);
   localparam logic [CW-1:0] RELOAD = CW'(INTERVAL - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= RELOAD;
         pend <= 1'b0;
      end else if (cnt == '0) begin
         cnt  <= RELOAD;
         pend <= 1'b1;
      end else begin
         cnt <= cnt - 1'b1;
         if (ack) pend <= 1'b0;
      end
   end

   // a refresh may only be issued while one is owed
   assert_ack_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> pend);

endmodule

// File: rtl/dram_ref_row.sv
module dram_ref_row #(
   parameter int unsigned ROW_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ack,
   output logic [ROW_W-1:0] row
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   row <= '0;
      else if (ack) row <= row + 1'b1;
   end
endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux
   import dram_ctrl_pkg::*;
#(
   parameter int unsigned PIN_W = 10
) (
   input  addr_sel_e        sel,
   input  logic [PIN_W-1:0] row,
   input  logic [PIN_W-1:0] col,
   input  logic [PIN_W-1:0] ref_row,
   output logic [PIN_W-1:0] pins
);
   always_comb begin
      unique case (sel)
         SEL_ROW: pins = row;
         SEL_REF: pins = ref_row;
         default: pins = col;
      endcase
   end
endmodule

// File: rtl/dram_mux_ctrl.sv
module dram_mux_ctrl
   import dram_ctrl_pkg::*;
#(
   parameter int unsigned ROW_W        = 10,
   parameter int unsigned COL_W        = 10,
   parameter int unsigned DATA_W       = 8,
   parameter int unsigned CLK_KHZ      = 200000,
   parameter int unsigned RETENTION_MS = 8,
   parameter int unsigned REF_INTERVAL = CLK_KHZ * RETENTION_MS / (1 << ROW_W),
   parameter int unsigned PRE_CYC      = 2,
   localparam int unsigned ADDR_W = ROW_W + COL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_done,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ROW_W-1:0]  mem_addr,
   output logic              mem_ras_n,
   output logic              mem_cas_n,
   output logic              mem_we_n,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in
);
   localparam int unsigned PW = (PRE_CYC > 1) ? $clog2(PRE_CYC + 1) : 1;
   localparam logic [PW-1:0] PRE_LOAD = PW'(PRE_CYC - 1);
   localparam int unsigned HW = $clog2(PRE_CYC + 3);
   localparam logic [HW-1:0] HI_MAX = HW'(PRE_CYC + 2);

   generate
      if (ROW_W != COL_W) begin : g_bad_split
         $error("row and column halves must share the pin width");
      end
      if (PRE_CYC < 1) begin : g_bad_pre
         $error("PRE_CYC must be at least 1");
      end
      if (REF_INTERVAL < 16) begin : g_bad_ref
         $error("REF_INTERVAL too short to fit an access");
      end
   endgenerate

   ctrl_st_e          state;
   pre_tgt_e          pre_tgt;
   logic [PW-1:0]     pre_cnt;
   logic              row_open;
   logic [ROW_W-1:0]  open_row;
   logic [ADDR_W-1:0] lat_addr;
   logic              lat_wr;
   logic [DATA_W-1:0] lat_wdata;
   logic              ref_pend;
   logic              ref_ack;
   logic [ROW_W-1:0]  ref_row;
   addr_sel_e         sel;

   wire [ROW_W-1:0] lat_row = lat_addr[ADDR_W-1:COL_W];
   wire [COL_W-1:0] lat_col = lat_addr[COL_W-1:0];
   wire [ROW_W-1:0] req_row = req_addr[ADDR_W-1:COL_W];

   assign ref_ack = (state == ST_FRAS);

   dram_ref_timer #(.INTERVAL(REF_INTERVAL)) u_timer (
      .clk(clk), .rst_n(rst_n), .ack(ref_ack), .pend(ref_pend)
   );

   dram_ref_row #(.ROW_W(ROW_W)) u_refrow (
      .clk(clk), .rst_n(rst_n), .ack(ref_ack), .row(ref_row)
   );

   always_comb begin
      unique case (state)
         ST_RSET, ST_RAS: sel = SEL_ROW;
         ST_FSET, ST_FRAS: sel = SEL_REF;
         default:          sel = SEL_COL;
      endcase
   end

   dram_addr_mux #(.PIN_W(ROW_W)) u_mux (
      .sel(sel), .row(lat_row), .col(lat_col), .ref_row(ref_row), .pins(mem_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         pre_tgt   <= PT_IDLE;
         pre_cnt   <= '0;
         row_open  <= 1'b0;
         open_row  <= '0;
         lat_addr  <= '0;
         lat_wr    <= 1'b0;
         lat_wdata <= '0;
         rsp_rdata <= '0;
         rsp_done  <= 1'b0;
      end else begin
         rsp_done <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (ref_pend) begin
                  if (row_open) begin
                     state    <= ST_PRE;
                     pre_tgt  <= PT_REF;
                     pre_cnt  <= PRE_LOAD;
                     row_open <= 1'b0;
                  end else begin
                     state <= ST_FSET;
                  end
               end else if (req_valid) begin
                  lat_addr  <= req_addr;
                  lat_wr    <= req_write;
                  lat_wdata <= req_wdata;
                  if (row_open && req_row == open_row) begin
                     state <= ST_CSET;
                  end else if (row_open) begin
                     state    <= ST_PRE;
                     pre_tgt  <= PT_ROW;
                     pre_cnt  <= PRE_LOAD;
                     row_open <= 1'b0;
                  end else begin
                     state <= ST_RSET;
                  end
               end
            end
            ST_PRE: begin
               if (pre_cnt == '0) begin
                  unique case (pre_tgt)
                     PT_ROW:  state <= ST_RSET;
                     PT_REF:  state <= ST_FSET;
                     default: state <= ST_IDLE;
                  endcase
               end else begin
                  pre_cnt <= pre_cnt - 1'b1;
               end
            end
            ST_RSET: state <= ST_RAS;
            ST_RAS: begin
               row_open <= 1'b1;
               open_row <= lat_row;
               state    <= ST_CSET;
            end
            ST_CSET: state <= ST_CAS;
            ST_CAS: begin
               rsp_done <= 1'b1;
               if (!lat_wr) rsp_rdata <= mem_dq_in;
               state <= ST_IDLE;
            end
            ST_FSET: state <= ST_FRAS;
            ST_FRAS: begin
               state   <= ST_PRE;
               pre_tgt <= PT_IDLE;
               pre_cnt <= PRE_LOAD;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign req_ready  = (state == ST_IDLE) && !ref_pend;
   assign mem_ras_n  = !((state == ST_RAS) || (state == ST_CSET) || (state == ST_CAS) ||
                         (state == ST_FRAS) || ((state == ST_IDLE) && row_open));
   assign mem_cas_n  = (state != ST_CAS);
   assign mem_we_n   = !((state == ST_CAS) && lat_wr);
   assign mem_dq_oe  = (state == ST_CAS) && lat_wr;
   assign mem_dq_out = lat_wdata;

   // ---------------- assertions ----------------
   logic [HW-1:0] hi_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         hi_cnt <= HI_MAX;
      else if (!mem_ras_n) hi_cnt <= '0;
      else if (hi_cnt != HI_MAX) hi_cnt <= hi_cnt + 1'b1;
   end

   assert_precharge_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_ras_n) |-> (hi_cnt >= HW'(PRE_CYC + 1)));

   assert_strobe_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_cas_n |-> !mem_ras_n);

   assert_row_setup_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_ras_n) |-> $stable(mem_addr));

   assert_col_setup_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_cas_n) |-> $stable(mem_addr));

   assert_write_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (!mem_cas_n && mem_dq_oe));

   assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);

   assert_busy_after_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

endmodule

// File: tb/dram_mux_ctrl_tb_top.sv
module dram_mux_ctrl_tb_top;
   localparam int PRE = 2;
   localparam int REFI = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [19:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        rsp_done;
   logic [7:0]  rsp_rdata;
   logic [9:0]  mem_addr;
   logic        mem_ras_n, mem_cas_n, mem_we_n, mem_dq_oe;
   logic [7:0]  mem_dq_out;
   logic [7:0]  mem_dq_in = 8'hEE;

   always #2.5 clk = ~clk;

   dram_mux_ctrl #(.REF_INTERVAL(REFI), .PRE_CYC(PRE)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
      .mem_addr(mem_addr), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n),
      .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
      .mem_dq_in(mem_dq_in)
   );

   int total = 0;
   int bad = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int got, input int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: got %0h exp %0h", req, what, got, expv);
      end
   endtask

   function automatic logic [7:0] dflt(input int a);
      return a[7:0] ^ a[19:12] ^ 8'h3C;
   endfunction

   // ---------------- memory model ----------------
   logic [7:0] mem_arr [int];
   logic [7:0] shadow [int];
   logic [9:0] cur_row = '0;
   logic       prev_ras = 1'b1, prev_cas = 1'b1;
   logic [9:0] prev_addr = '0;
   int  hi = 1000;
   bit  cas_seen = 1'b1;
   int  ras_falls = 0, wr_cnt = 0, rd_cnt = 0;
   int  ref_cnt = 0, exp_ref = 0;
   int  cyc = 0, last_ref = 0;
   bit  b_open = 1'b0;
   logic [9:0] b_row = '0;

   always @(negedge clk) begin
      if (rst_n) cyc++;
      if (!mem_cas_n) begin
         int a;
         a = {12'd0, cur_row, mem_addr};
         chk(!mem_ras_n, "R2", "cas while ras high", mem_ras_n, 0);
         if (prev_cas) chk(mem_addr == prev_addr, "R2", "col setup", mem_addr, prev_addr);
         cas_seen = 1'b1;
         if (!mem_we_n) begin
            chk(mem_dq_oe, "R3", "oe on write", mem_dq_oe, 1);
            mem_arr[a] = mem_dq_out;
            wr_cnt++;
         end else begin
            if (mem_dq_oe) chk(1'b0, "R3", "oe on read", mem_dq_oe, 0);
            mem_dq_in = mem_arr.exists(a) ? mem_arr[a] : dflt(a);
            rd_cnt++;
         end
      end else begin
         mem_dq_in = 8'hEE;
         if (!mem_we_n) chk(1'b0, "R3", "we_n low without cas", mem_we_n, 1);
      end
      if (!mem_ras_n && prev_ras) begin
         chk(hi >= PRE + 1, "R7", "ras high cycles", hi, PRE + 1);
         chk(mem_addr == prev_addr, "R2", "row setup", mem_addr, prev_addr);
         cur_row = mem_addr;
         cas_seen = 1'b0;
         ras_falls++;
         hi = 0;
      end
      if (mem_ras_n && !prev_ras && !cas_seen) begin
         chk(cur_row == 10'(exp_ref), "R8", "refresh row", cur_row, exp_ref);
         chk(cyc - last_ref <= REFI + 20, "R9", "refresh gap", cyc - last_ref, REFI + 20);
         last_ref = cyc;
         exp_ref = (exp_ref + 1) % 1024;
         ref_cnt++;
         b_open = 1'b0;
      end
      if (mem_ras_n) hi++;
      prev_ras = mem_ras_n;
      prev_cas = mem_cas_n;
      prev_addr = mem_addr;
   end

   // ---------------- scoreboard ----------------
   typedef struct {
      logic [19:0] addr;
      bit          wr;
      logic [7:0]  data;
      int          ras0, wr0, rd0, exp_falls;
   } item_t;
   item_t q[$];
   int dones = 0, accepted = 0;

   always @(negedge clk) begin
      if (rst_n && rsp_done) begin
         dones++;
         if (q.size() == 0) begin
            chk(1'b0, "R5", "unexpected done", 1, 0);
         end else begin
            item_t it;
            it = q.pop_front();
            chk(ras_falls - it.ras0 == it.exp_falls, "R6", "row strobes", ras_falls - it.ras0, it.exp_falls);
            chk(wr_cnt - it.wr0 == (it.wr ? 1 : 0), "R3", "write strobes", wr_cnt - it.wr0, it.wr ? 1 : 0);
            chk(rd_cnt - it.rd0 == (it.wr ? 0 : 1), "R3", "read strobes", rd_cnt - it.rd0, it.wr ? 0 : 1);
            if (!it.wr) chk(rsp_rdata == it.data, "R1", "read data", rsp_rdata, it.data);
            b_open = 1'b1;
            b_row = it.addr[19:10];
         end
      end
   end

   task automatic access(input bit wr, input logic [19:0] addr, input logic [7:0] data);
      item_t it;
      int a;
      a = {12'd0, addr};
      while (q.size() != 0) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b1;
      req_write = wr;
      req_addr  = addr;
      req_wdata = data;
      while (!req_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      accepted++;
      chk(!req_ready, "R4", "ready after accept", req_ready, 0);
      it.addr = addr;
      it.wr = wr;
      it.ras0 = ras_falls;
      it.wr0 = wr_cnt;
      it.rd0 = rd_cnt;
      it.exp_falls = (b_open && b_row == addr[19:10]) ? 0 : 1;
      if (wr) begin
         shadow[a] = data;
         it.data = data;
      end else begin
         it.data = shadow.exists(a) ? shadow[a] : dflt(a);
      end
      q.push_back(it);
   endtask

   task automatic run_tests();
      logic [31:0] lf;
      repeat (4) @(negedge clk);
      chk(mem_ras_n && mem_cas_n && mem_we_n && !mem_dq_oe && !rsp_done, "R4", "strobes in reset",
          {mem_ras_n, mem_cas_n, mem_we_n, mem_dq_oe, rsp_done}, 5'b11100);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready, "R4", "ready out of reset", req_ready, 1);

      // same-row hits and a row change (R1, R3, R6)
      access(1'b1, 20'h12345, 8'hA5);
      access(1'b0, 20'h12345, 8'h00);
      access(1'b1, 20'h12346, 8'h5A);
      access(1'b0, 20'h12346, 8'h00);
      access(1'b0, 20'h55555, 8'h00);
      access(1'b0, 20'h12345, 8'h00);

      // sequential walk across a row boundary
      for (int i = 0; i < 8; i++) access(1'b1, 20'h003FC + 20'(i), 8'(8'h10 + i));
      for (int i = 0; i < 8; i++) access(1'b0, 20'h003FC + 20'(i), 8'h00);

      // address extremes
      access(1'b1, 20'h00000, 8'hC3);
      access(1'b1, 20'hFFFFF, 8'h3C);
      access(1'b0, 20'h00000, 8'h00);
      access(1'b0, 20'hFFFFF, 8'h00);

      // scattered mix over four rows; refreshes interleave
      lf = 32'hACE1_2468;
      for (int i = 0; i < 80; i++) begin
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         access(lf[20], {8'h00, lf[1:0], lf[13:4]}, lf[31:24]);
      end

      // long idle: refresh row counter wraps (R8, R9)
      while (q.size() != 0) @(negedge clk);
      repeat (1100 * REFI) @(negedge clk);
      chk(ref_cnt > 1024, "R8", "refresh count past wrap", ref_cnt, 1025);
      access(1'b0, 20'h003FF, 8'h00);
      while (q.size() != 0) @(negedge clk);
      repeat (4) @(negedge clk);
      chk(dones == accepted, "R5", "one done per request", dones, accepted);
   endtask

   initial begin
      fork
         run_tests();
         begin
            repeat (190000) @(posedge clk);
            bad++;
            total++;
            $display("FAIL R5 watchdog: got timeout exp completion");
         end
      join_any
      disable fork;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule